// File: doc/BRIEF.md
# Debug Port Memory Write Sequencer

This block sits behind a serial debug port and runs one memory write command. The port hands it 16-bit packets one at a time. The first packet is the command word, which carries the operand size. The next two packets are the 32-bit target address. The last one or two packets are the data. After the last operand the block issues a single write on a simple valid/ready memory bus. It then waits for the bus response and turns that response into a status packet.

Responses run one exchange behind the packets. Each time the port presents a packet, `rsp_out` is the answer to the packet before it. On the clock edge that accepts the packet, `rsp_out` is loaded with the answer to the packet just taken.

- While operands are still arriving, and while the bus cycle is running, the answer is "not ready".
- Once the bus replies, `rsp_out` holds a completion pattern or an error pattern.
- The host collects that result in the same exchange that shifts in its next command.

Top module: `dbg_memwr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `rsp_out` to the not-ready value {status 0, data 0x0000}, deasserts `bus_req_valid` and leaves the block waiting for a command.
- R2: Accepted packets are taken in a fixed order. First the command, then the upper address half, then the lower address half, then the data. Each accepted command or operand packet loads `rsp_out` with not-ready. `bus_req_valid` rises in the cycle after the final operand is accepted.
- R3: `bus_addr` equals {first address packet, second address packet}.
- R4: Byte size: bits [7:0] of the data packet are copied into all four byte lanes of `bus_wdata`, and `bus_be` is one-hot at lane `bus_addr[1:0]`. Lane n is bits 8n+7..8n.
- R5: Word size: the data packet is copied into both halves of `bus_wdata`. `bus_be` is 4'b0011 when `bus_addr[1]` is 0 and 4'b1100 when it is 1.
- R6: Long size takes two data packets, most significant half first. `bus_wdata` is their concatenation and `bus_be` is 4'b1111.
- R7: The size is bits [1:0] of the command word: 00 byte, 01 word, 10 long. A value of 11 loads `rsp_out` with the error pattern. No bus request is made, and the block keeps waiting for a command.
- R8: A bus request holds `bus_req_valid`, `bus_addr`, `bus_wdata` and `bus_be` steady until `bus_req_ready` is seen. Exactly one request is made per command.
- R9: Once the request has been accepted, a `bus_rsp_valid` with `bus_rsp_err` low loads `rsp_out` with {0, 0xFFFF}. With `bus_rsp_err` high it loads {1, 0x0001}. The block then waits for a command.
- R10: Packets presented while a bus cycle is pending or in flight are ignored. `rsp_out` stays not-ready and the request fields do not change.
- R11: A command presented while a result is held is accepted. That exchange returns the result, and `rsp_out` then becomes not-ready.
- R12: A reset in the middle of a command discards the partial operands. The next packet is taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_in_valid | input | 1 | One-cycle strobe marking a packet exchange |
| pkt_in | input | 16 | Incoming packet data |
| rsp_out | output | 17 | Response for the previous exchange: bit 16 status, bits 15:0 data |
| bus_req_valid | output | 1 | Write request valid |
| bus_req_ready | input | 1 | Write request accepted |
| bus_addr | output | 32 | Write address |
| bus_wdata | output | 32 | Write data, lane-replicated for narrow sizes |
| bus_be | output | 4 | Byte enables |
| bus_rsp_valid | input | 1 | Bus response strobe |
| bus_rsp_err | input | 1 | Bus response is an error |

## Verification
The bound checker watches several rules on every cycle:
- the request fields stay stable until the handshake, and only one request is made per command;
- enables are never zero during a request;
- `rsp_out` only ever shows one of its three legal codes, and it stays not-ready while a bus cycle is open;
- the result code follows the bus error flag.

Other behaviour can only be shown by the directed scenarios:
- how packets are assembled into address and data;
- lane replication and enables for each size and alignment;
- rejection of the reserved size;
- collection of a result alongside the next command;
- recovery from a reset in the middle of a command.

// File: rtl/dbg_memwr_seq.sv
module dbg_memwr_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        pkt_in_valid,
  input  logic [15:0] pkt_in,
  output logic [16:0] rsp_out,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic [3:0]  bus_be,
  input  logic        bus_rsp_valid,
  input  logic        bus_rsp_err
);
  localparam logic [2:0] S_CMD = 3'd0, S_AHI = 3'd1, S_ALO = 3'd2, S_DHI = 3'd3,
                         S_DLO = 3'd4, S_REQ = 3'd5, S_WAIT = 3'd6;
  localparam logic [16:0] RSP_NR  = 17'h00000;
  localparam logic [16:0] RSP_OK  = 17'h0FFFF;
  localparam logic [16:0] RSP_ERR = 17'h10001;
  localparam logic [1:0] SZ_BYTE = 2'b00, SZ_WORD = 2'b01, SZ_LONG = 2'b10, SZ_BAD = 2'b11;

  logic [2:0]  state_q;
  logic [1:0]  size_q;
  logic [31:0] addr_q, data_q;
  logic [16:0] rsp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_CMD;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      data_q  <= '0;
      rsp_q   <= RSP_NR;
    end else begin
      case (state_q)
        S_CMD: if (pkt_in_valid) begin
          if (pkt_in[1:0] == SZ_BAD) rsp_q <= RSP_ERR;
          else begin
            size_q  <= pkt_in[1:0];
            rsp_q   <= RSP_NR;
            state_q <= S_AHI;
          end
        end
        S_AHI: if (pkt_in_valid) begin
          addr_q[31:16] <= pkt_in;
          rsp_q         <= RSP_NR;
          state_q       <= S_ALO;
        end
        S_ALO: if (pkt_in_valid) begin
          addr_q[15:0] <= pkt_in;
          rsp_q        <= RSP_NR;
          state_q      <= (size_q == SZ_LONG) ? S_DHI : S_DLO;
        end
        S_DHI: if (pkt_in_valid) begin
          data_q[31:16] <= pkt_in;
          rsp_q         <= RSP_NR;
          state_q       <= S_DLO;
        end
        S_DLO: if (pkt_in_valid) begin
          data_q[15:0] <= pkt_in;
          rsp_q        <= RSP_NR;
          state_q      <= S_REQ;
        end
        S_REQ: if (bus_req_ready) state_q <= S_WAIT;
        S_WAIT: if (bus_rsp_valid) begin
          rsp_q   <= bus_rsp_err ? RSP_ERR : RSP_OK;
          state_q <= S_CMD;
        end
        default: state_q <= S_CMD;
      endcase
    end
  end

  assign rsp_out       = rsp_q;
  assign bus_req_valid = (state_q == S_REQ);
  assign bus_addr      = addr_q;

  always_comb begin
    case (size_q)
      SZ_BYTE: begin
        bus_wdata = {4{data_q[7:0]}};
        bus_be    = 4'b0001 << addr_q[1:0];
      end
      SZ_WORD: begin
        bus_wdata = {2{data_q[15:0]}};
        bus_be    = addr_q[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        bus_wdata = data_q;
        bus_be    = 4'b1111;
      end
    endcase
  end
endmodule

module dbg_memwr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        pkt_in_valid,
  input logic [16:0] rsp_out,
  input logic        bus_req_valid,
  input logic        bus_req_ready,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_be,
  input logic        bus_rsp_valid,
  input logic        bus_rsp_err,
  input logic [2:0]  state_q
);
  localparam logic [2:0] C_REQ = 3'd5, C_WAIT = 3'd6;

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) && !rst |-> !bus_req_valid && rsp_out == 17'h00000);

  a_r2_req_after_pkt: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_valid) |-> $past(pkt_in_valid));

  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> bus_be != 4'b0000);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_addr)
      && $stable(bus_wdata) && $stable(bus_be));

  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && bus_req_ready |=> !bus_req_valid);

  a_r9_codes: assert property (@(posedge clk) disable iff (rst)
    rsp_out == 17'h00000 || rsp_out == 17'h0FFFF || rsp_out == 17'h10001);

  a_r9_result: assert property (@(posedge clk) disable iff (rst)
    state_q == C_WAIT && bus_rsp_valid |=>
      rsp_out == ($past(bus_rsp_err) ? 17'h10001 : 17'h0FFFF));

  a_r10_busy_nr: assert property (@(posedge clk) disable iff (rst)
    (state_q == C_REQ || state_q == C_WAIT) |-> rsp_out == 17'h00000);
endmodule

bind dbg_memwr_seq dbg_memwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .pkt_in_valid(pkt_in_valid), .rsp_out(rsp_out),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
  .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err), .state_q(state_q)
);

// File: tb/dbg_memwr_seq_test.sv
module dbg_memwr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_in_valid = 1'b0;
  logic [15:0] pkt_in = '0;
  logic [16:0] rsp_out;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0;

  localparam logic [16:0] NR = 17'h00000, OK = 17'h0FFFF, ERR = 17'h10001;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  dbg_memwr_seq uut (
    .clk(clk), .rst(rst), .pkt_in_valid(pkt_in_valid), .pkt_in(pkt_in),
    .rsp_out(rsp_out), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] d, output logic [16:0] r);
    @(negedge clk);
    r = rsp_out;
    pkt_in_valid = 1'b1;
    pkt_in = d;
    @(negedge clk);
    pkt_in_valid = 1'b0;
  endtask

  task automatic bus_done(input int wt, input bit err, input logic [31:0] ea,
                          input logic [31:0] ewd, input logic [3:0] ebe, input string tag);
    for (int i = 0; i < wt; i++) begin
      chk(bus_req_valid, {"R8 held ", tag}, {35'd0, bus_req_valid}, 36'd1);
      @(negedge clk);
    end
    chk(bus_req_valid, {"R2 req ", tag}, {35'd0, bus_req_valid}, 36'd1);
    chk(bus_addr == ea, {"R3 addr ", tag}, {4'd0, bus_addr}, {4'd0, ea});
    chk(bus_wdata == ewd, {"R4 R5 R6 wdata ", tag}, {4'd0, bus_wdata}, {4'd0, ewd});
    chk(bus_be == ebe, {"R4 R5 R6 be ", tag}, {32'd0, bus_be}, {32'd0, ebe});
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
    chk(!bus_req_valid, {"R8 single ", tag}, {35'd0, bus_req_valid}, 36'd0);
    chk(rsp_out == NR, {"R10 wait nr ", tag}, {19'd0, rsp_out}, {19'd0, NR});
    bus_rsp_valid = 1'b1;
    bus_rsp_err = err;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
    bus_rsp_err = 1'b0;
    chk(rsp_out == (err ? ERR : OK), {"R9 result ", tag}, {19'd0, rsp_out},
        {19'd0, err ? ERR : OK});
  endtask

  task automatic write_op(input logic [1:0] sz, input logic [31:0] a, input logic [15:0] dhi,
                          input logic [15:0] dlo, input int wt, input bit err,
                          input logic [31:0] ewd, input logic [3:0] ebe,
                          input logic [16:0] prev, input string tag);
    logic [16:0] r;
    xfer({14'h0200, sz}, r);
    chk(r == prev, {"R11 prev result ", tag}, {19'd0, r}, {19'd0, prev});
    xfer(a[31:16], r);
    chk(r == NR, {"R2 cmd nr ", tag}, {19'd0, r}, {19'd0, NR});
    xfer(a[15:0], r);
    chk(r == NR, {"R2 ahi nr ", tag}, {19'd0, r}, {19'd0, NR});
    if (sz == 2'b10) begin
      xfer(dhi, r);
      chk(r == NR, {"R6 alo nr ", tag}, {19'd0, r}, {19'd0, NR});
    end
    xfer(dlo, r);
    chk(r == NR, {"R2 op nr ", tag}, {19'd0, r}, {19'd0, NR});
    bus_done(wt, err, a, ewd, ebe, tag);
  endtask

  task automatic t_reset;
    chk(rsp_out == NR, "R1 rsp", {19'd0, rsp_out}, {19'd0, NR});
    chk(!bus_req_valid, "R1 req", {35'd0, bus_req_valid}, 36'd0);
  endtask

  task automatic t_byte;
    write_op(2'b00, 32'h1000_0003, 16'h0, 16'h12A5, 0, 1'b0, 32'hA5A5_A5A5, 4'b1000, NR, "byte3");
    write_op(2'b00, 32'h1000_0001, 16'h0, 16'h003C, 2, 1'b0, 32'h3C3C_3C3C, 4'b0010, OK, "byte1");
  endtask

  task automatic t_word;
    write_op(2'b01, 32'h2000_0002, 16'h0, 16'hBEEF, 1, 1'b0, 32'hBEEF_BEEF, 4'b1100, OK, "word2");
    write_op(2'b01, 32'h2000_0000, 16'h0, 16'h1234, 0, 1'b0, 32'h1234_1234, 4'b0011, OK, "word0");
  endtask

  task automatic t_long_err;
    write_op(2'b10, 32'h3000_0000, 16'hDEAD, 16'hBEEF, 3, 1'b1, 32'hDEAD_BEEF, 4'b1111, OK, "long");
  endtask

  task automatic t_badsize;
    logic [16:0] r;
    xfer(16'h0203, r);
    chk(r == ERR, "R11 result before bad", {19'd0, r}, {19'd0, ERR});
    chk(rsp_out == ERR, "R7 bad size err", {19'd0, rsp_out}, {19'd0, ERR});
    repeat (3) @(negedge clk);
    chk(!bus_req_valid, "R7 no bus cycle", {35'd0, bus_req_valid}, 36'd0);
    write_op(2'b00, 32'h4000_0002, 16'h0, 16'h0077, 0, 1'b0, 32'h7777_7777, 4'b0100, ERR, "R7 after bad");
  endtask

  task automatic t_busy;
    logic [16:0] r;
    xfer(16'h0201, r);
    chk(r == OK, "R11 result", {19'd0, r}, {19'd0, OK});
    xfer(16'h5000, r);
    xfer(16'h0000, r);
    xfer(16'hCAFE, r);
    xfer(16'h5555, r);
    chk(r == NR, "R10 busy ret", {19'd0, r}, {19'd0, NR});
    chk(rsp_out == NR, "R10 busy rsp", {19'd0, rsp_out}, {19'd0, NR});
    chk(bus_addr == 32'h5000_0000, "R10 addr kept", {4'd0, bus_addr}, 36'h0_5000_0000);
    chk(bus_wdata == 32'hCAFE_CAFE, "R10 data kept", {4'd0, bus_wdata}, 36'h0_CAFE_CAFE);
    bus_done(0, 1'b0, 32'h5000_0000, 32'hCAFE_CAFE, 4'b0011, "busy");
  endtask

  task automatic t_midreset;
    logic [16:0] r;
    xfer(16'h0202, r);
    xfer(16'h6000, r);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rsp_out == NR, "R12 rsp after reset", {19'd0, rsp_out}, {19'd0, NR});
    chk(!bus_req_valid, "R12 req after reset", {35'd0, bus_req_valid}, 36'd0);
    write_op(2'b01, 32'h7000_0002, 16'h0, 16'h4242, 0, 1'b0, 32'h4242_4242, 4'b1100, NR, "R12 fresh");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_byte();
    t_word();
    t_long_err();
    t_badsize();
    t_busy();
    t_midreset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule